// File: doc/BRIEF.md
# Seek Difference Counter Sequencer

This block is the digital half of a head-positioning servo. It holds the present cylinder address and a target, and runs a seek by preloading an up-counter with the one's complement of the seek length. Each gated cylinder-crossing pulse advances the counter, and the all-ones state means the carriage has arrived. The remaining distance is decoded into mutually exclusive phase strobes that steer the analog loops. A direction flag is also given, along with an odd-target flag that sets the polarity of the track-servo signal.

A return-to-zero command recalibrates the carriage. It clears the cylinder register and the counter, and the carriage is driven backward until the analog on-cylinder comparator reports arrival. The unit then declares itself ready. A loss-of-servo-pattern monitor latches a fault that cancels motion. The fault blocks every further command until it is cleared. The analog position and velocity loops are outside the block and appear only as the crossing pulse and the on-cylinder comparator input.

Top module: `seek_seq`

## Requirements
- R1: An accepted seek of length L loads the counter with the complement of L, so `tracks_to_go` reads L on the next cycle. Each `cyl_pulse` during a seek lowers it by one. At zero it holds, and further pulses are ignored.
- R2: `dir_fwd` is 1 for a seek whose target exceeds `cur_cyl`, and 0 for a seek toward a lower cylinder or for return-to-zero.
- R3: `odd_cyl` equals bit 0 of the most recently accepted target (0 after return-to-zero). `servo_inv` is 1 when that target is even and 0 when it is odd.
- R4: While seeking, exactly one phase strobe is high. `ph_stop` is high when `tracks_to_go` is 1 or less. `ph_linear` is high when it is from 2 to LIN_ZONE (default 32). Above LIN_ZONE, `ph_accel` is high before the first crossing pulse and `ph_coarse` is high after it. Outside a seek, all four are low.
- R5: When `tracks_to_go` is 0 and `on_cyl_in` is high during a seek, the next cycle shows `seek_done` high for one cycle, `cur_cyl` equal to the target, `busy` low and `on_cyl` high.
- R6: A seek to the present cylinder pulses `seek_done` on the next cycle. It leaves `busy` low and `on_cyl` high.
- R7: A seek request is rejected and `seek_err` is set in these cases: while busy, before ready, or while faulted. A return-to-zero request during a seek is also rejected and sets `seek_err`. A rejected request changes neither the target nor the count. `seek_err` stays set until the next accepted command.
- R8: Return-to-zero clears `cur_cyl` and `ready` and raises `busy` and `rtz_active`. During it, `tracks_to_go` reads all ones (511 at default width) and crossing pulses are ignored. `on_cyl_in` then ends it with a `seek_done` pulse, `ready` high and `tracks_to_go` 0.
- R9: If `dibit_ok` is low for LOSS_CYC consecutive sampled cycles while busy or ready, `fault` rises and the seek is cancelled, so `busy` and `ready` go low. A shorter dropout has no effect. While `fault` is set, return-to-zero and seeks are refused. `fault_clr` clears it.
- R10: After reset the block is idle and not ready. `fault`, `seek_err` and `seek_done` are low, `cur_cyl` and `tracks_to_go` are 0, and `servo_inv` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seek_req | input | 1 | Seek command strobe |
| seek_cyl | input | CYL_W | Target cylinder for seek_req |
| rtz_req | input | 1 | Return-to-zero command strobe |
| cyl_pulse | input | 1 | Gated cylinder-crossing pulse |
| on_cyl_in | input | 1 | Analog on-cylinder comparator |
| dibit_ok | input | 1 | Servo pattern present |
| fault_clr | input | 1 | Clears the latched fault |
| busy | output | 1 | Seek or return-to-zero in progress |
| rtz_active | output | 1 | Return-to-zero in progress |
| ph_accel | output | 1 | Acceleration phase |
| ph_coarse | output | 1 | Coarse position phase |
| ph_linear | output | 1 | Integrated-velocity phase |
| ph_stop | output | 1 | Stop / fine-position phase |
| on_cyl | output | 1 | Ready and idle on a cylinder |
| dir_fwd | output | 1 | Seek direction, 1 = toward higher cylinders |
| odd_cyl | output | 1 | Target cylinder is odd |
| servo_inv | output | 1 | Invert track-servo signal |
| seek_done | output | 1 | One-cycle completion pulse |
| ready | output | 1 | Unit recalibrated and usable |
| seek_err | output | 1 | Last command was rejected |
| fault | output | 1 | Servo pattern loss latched |
| cur_cyl | output | CYL_W | Present cylinder address |
| tracks_to_go | output | CYL_W | Remaining crossings in the current seek |

## Verification
Two events can land on the same clock edge: a seek completing and a new seek request arriving. At that edge `busy` is still high, so the request must be refused even though the block goes idle on that very edge. The bench makes this happen by driving `on_cyl_in` and `seek_req` in the same cycle once `tracks_to_go` reaches 0. It then expects `seek_done` and `seek_err` together on the following cycle, with `cur_cyl` at the old target. The next request, issued one cycle later, must be accepted and must clear `seek_err`.

// File: rtl/seek_seq_pkg.sv
package seek_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SEEK = 2'd1,
    SQ_RTZ  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/sq_diff_counter.sv
module sq_diff_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] diff,
  output logic         at_end
);
  assign at_end = &diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                diff <= '1;
    else if (load)             diff <= load_val;
    else if (step && !at_end)  diff <= diff + 1'b1;
  end

  // R1: a step away from the terminal count advances by exactly one
  a_r1_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
    step && !at_end && !load |=> diff == $past(diff) + 1'b1);

  // R1: terminal count is sticky until the next load
  a_r1_end_hold: assert property (@(posedge clk) disable iff (!rst_n)
    at_end && !load |=> at_end);
endmodule

// File: rtl/sq_phase_decode.sv
module sq_phase_decode #(
  parameter int W        = 9,
  parameter int LIN_ZONE = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         seen,
  input  logic [W-1:0] diff,
  output logic         ph_accel,
  output logic         ph_coarse,
  output logic         ph_linear,
  output logic         ph_stop
);
  localparam logic [W-1:0] LIN_V = LIN_ZONE[W-1:0];
  localparam logic [W-1:0] ONE_V = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] togo;
  logic         near_stop;
  logic         in_lin;

  assign togo      = ~diff;
  assign near_stop = togo <= ONE_V;
  assign in_lin    = togo <= LIN_V;

  always_comb begin
    ph_stop   = active && near_stop;
    ph_linear = active && !near_stop && in_lin;
    ph_accel  = active && !in_lin && !seen;
    ph_coarse = active && !in_lin && seen;
  end

  // R4: never two phases at once
  a_r4_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ph_accel, ph_coarse, ph_linear, ph_stop}));

  // R4: acceleration is never re-entered straight from coarse
  a_r4_no_reaccel: assert property (@(posedge clk) disable iff (!rst_n)
    ph_coarse |=> !ph_accel);
endmodule

// File: rtl/sq_dibit_watch.sv
module sq_dibit_watch #(
  parameter int LOSS_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon,
  input  logic dibit_ok,
  output logic expire
);
  localparam int CW = $clog2(LOSS_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(LOSS_CYC - 1);

  logic [CW-1:0] cnt;

  assign expire = mon && !dibit_ok && (cnt == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!mon || dibit_ok) cnt <= '0;
    else if (cnt != LIM)       cnt <= cnt + 1'b1;
  end

  // R9: any sample of a healthy pattern restarts the loss window
  a_r9_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    dibit_ok |=> cnt == '0);
endmodule

// File: rtl/seek_seq.sv
module seek_seq
  import seek_seq_pkg::*;
#(
  parameter int CYL_W    = 9,
  parameter int LIN_ZONE = 32,
  parameter int LOSS_CYC = 50_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seek_req,
  input  logic [CYL_W-1:0] seek_cyl,
  input  logic             rtz_req,
  input  logic             cyl_pulse,
  input  logic             on_cyl_in,
  input  logic             dibit_ok,
  input  logic             fault_clr,
  output logic             busy,
  output logic             rtz_active,
  output logic             ph_accel,
  output logic             ph_coarse,
  output logic             ph_linear,
  output logic             ph_stop,
  output logic             on_cyl,
  output logic             dir_fwd,
  output logic             odd_cyl,
  output logic             servo_inv,
  output logic             seek_done,
  output logic             ready,
  output logic             seek_err,
  output logic             fault,
  output logic [CYL_W-1:0] cur_cyl,
  output logic [CYL_W-1:0] tracks_to_go
);
  function automatic logic [CYL_W-1:0] seek_len(input logic [CYL_W-1:0] a,
                                                input logic [CYL_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  sq_state_e        st;
  logic [CYL_W-1:0] cur_q, tgt_q, diff;
  logic             fwd_q, odd_q, seen_q, done_q, err_q, ready_q, fault_q;
  logic             at_end, expire;

  // named internal events
  logic start_rtz, acc_seek, zero_len, arrive, rtz_arr, ld, step;
  logic [CYL_W-1:0] ld_val;

  always_comb begin
    start_rtz = (st == SQ_IDLE) && !expire && rtz_req && !fault_q;
    acc_seek  = (st == SQ_IDLE) && !expire && !start_rtz && seek_req &&
                ready_q && !fault_q && (seek_cyl != cur_q);
    zero_len  = (st == SQ_IDLE) && !expire && !start_rtz && seek_req &&
                ready_q && !fault_q && (seek_cyl == cur_q);
    arrive    = (st == SQ_SEEK) && !expire && at_end && on_cyl_in;
    rtz_arr   = (st == SQ_RTZ) && !expire && on_cyl_in;
    ld        = acc_seek || start_rtz || rtz_arr;
    ld_val    = acc_seek ? ~seek_len(seek_cyl, cur_q) : (start_rtz ? '0 : '1);
    step      = (st == SQ_SEEK) && cyl_pulse && !expire;
  end

  sq_diff_counter #(.W(CYL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val),
    .step(step), .diff(diff), .at_end(at_end));

  sq_phase_decode #(.W(CYL_W), .LIN_ZONE(LIN_ZONE)) u_phase (
    .clk(clk), .rst_n(rst_n), .active(st == SQ_SEEK), .seen(seen_q),
    .diff(diff), .ph_accel(ph_accel), .ph_coarse(ph_coarse),
    .ph_linear(ph_linear), .ph_stop(ph_stop));

  sq_dibit_watch #(.LOSS_CYC(LOSS_CYC)) u_watch (
    .clk(clk), .rst_n(rst_n), .mon((st != SQ_IDLE) || ready_q),
    .dibit_ok(dibit_ok), .expire(expire));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      cur_q   <= '0;
      tgt_q   <= '0;
      fwd_q   <= 1'b0;
      odd_q   <= 1'b0;
      seen_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ready_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (fault_clr) fault_q <= 1'b0;
      if (expire) begin
        fault_q <= 1'b1;
        ready_q <= 1'b0;
        st      <= SQ_IDLE;
      end else begin
        case (st)
          SQ_IDLE: begin
            if (start_rtz) begin
              st      <= SQ_RTZ;
              cur_q   <= '0;
              tgt_q   <= '0;
              fwd_q   <= 1'b0;
              odd_q   <= 1'b0;
              ready_q <= 1'b0;
              err_q   <= 1'b0;
            end else if (acc_seek) begin
              st     <= SQ_SEEK;
              tgt_q  <= seek_cyl;
              fwd_q  <= seek_cyl > cur_q;
              odd_q  <= seek_cyl[0];
              seen_q <= 1'b0;
              err_q  <= 1'b0;
            end else if (zero_len) begin
              tgt_q  <= seek_cyl;
              odd_q  <= seek_cyl[0];
              done_q <= 1'b1;
              err_q  <= 1'b0;
            end else if (seek_req) begin
              err_q <= 1'b1;
            end
          end
          SQ_SEEK: begin
            if (seek_req || rtz_req) err_q <= 1'b1;
            if (arrive) begin
              st     <= SQ_IDLE;
              cur_q  <= tgt_q;
              done_q <= 1'b1;
            end else if (cyl_pulse) begin
              seen_q <= 1'b1;
            end
          end
          SQ_RTZ: begin
            if (seek_req) err_q <= 1'b1;
            if (rtz_arr) begin
              st      <= SQ_IDLE;
              ready_q <= 1'b1;
              done_q  <= 1'b1;
            end
          end
          default: st <= SQ_IDLE;
        endcase
      end
    end
  end

  assign busy         = st != SQ_IDLE;
  assign rtz_active   = st == SQ_RTZ;
  assign on_cyl       = ready_q && (st == SQ_IDLE);
  assign dir_fwd      = fwd_q;
  assign odd_cyl      = odd_q;
  assign servo_inv    = !odd_q;
  assign seek_done    = done_q;
  assign ready        = ready_q;
  assign seek_err     = err_q;
  assign fault        = fault_q;
  assign cur_cyl      = cur_q;
  assign tracks_to_go = ~diff;

  // R5: a completion pulse always leaves the register at the target
  a_r5_done_cur: assert property (@(posedge clk) disable iff (!rst_n)
    seek_done |-> cur_cyl == tgt_q);

  // R7: a request while busy is always flagged
  a_r7_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
    busy && seek_req |=> seek_err);

  // R9: a latched fault means no motion
  a_r9_fault_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !busy);

  // R8: return-to-zero leaves the cylinder register at zero
  a_r8_rtz_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rtz_active |-> cur_cyl == '0);
endmodule

// File: tb/seek_seq_tb.sv
module seek_seq_tb;
  localparam int W    = 9;
  localparam int LIN  = 32;
  localparam int LOSS = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seek_req = 1'b0, rtz_req = 1'b0, cyl_pulse = 1'b0;
  logic on_cyl_in = 1'b0, dibit_ok = 1'b1, fault_clr = 1'b0;
  logic [W-1:0] seek_cyl = '0;
  logic busy, rtz_active, ph_accel, ph_coarse, ph_linear, ph_stop, on_cyl;
  logic dir_fwd, odd_cyl, servo_inv, seek_done, ready, seek_err, fault;
  logic [W-1:0] cur_cyl, tracks_to_go;

  always #2 clk = ~clk;

  seek_seq #(.CYL_W(W), .LIN_ZONE(LIN), .LOSS_CYC(LOSS)) u_dut (
    .clk(clk), .rst_n(rst_n), .seek_req(seek_req), .seek_cyl(seek_cyl),
    .rtz_req(rtz_req), .cyl_pulse(cyl_pulse), .on_cyl_in(on_cyl_in),
    .dibit_ok(dibit_ok), .fault_clr(fault_clr), .busy(busy),
    .rtz_active(rtz_active), .ph_accel(ph_accel), .ph_coarse(ph_coarse),
    .ph_linear(ph_linear), .ph_stop(ph_stop), .on_cyl(on_cyl),
    .dir_fwd(dir_fwd), .odd_cyl(odd_cyl), .servo_inv(servo_inv),
    .seek_done(seek_done), .ready(ready), .seek_err(seek_err),
    .fault(fault), .cur_cyl(cur_cyl), .tracks_to_go(tracks_to_go));

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: mode 0 idle, 1 seek, 2 return-to-zero
  int m_mode = 0, m_togo = 0, m_tgt = 0, m_cur = 0, m_low = 0;
  bit m_fwd = 0, m_odd = 0, m_seen = 0, m_done = 0, m_err = 0;
  bit m_ready = 0, m_fault = 0;

  always @(posedge clk) begin
    bit watching, lost;
    int want;
    if (!rst_n) begin
      m_mode = 0; m_togo = 0; m_tgt = 0; m_cur = 0; m_low = 0;
      m_fwd = 0; m_odd = 0; m_seen = 0; m_done = 0; m_err = 0;
      m_ready = 0; m_fault = 0;
    end else begin
      watching = (m_mode != 0) || m_ready;
      if (watching && !dibit_ok) m_low = m_low + 1; else m_low = 0;
      lost = watching && (m_low >= LOSS);
      want = int'(seek_cyl);
      m_done = 0;
      if (fault_clr) m_fault = 0;
      if (lost) begin
        m_fault = 1; m_ready = 0; m_mode = 0; m_low = 0;
      end else if (m_mode == 0) begin
        if (rtz_req && !m_fault) begin
          m_mode = 2; m_cur = 0; m_tgt = 0; m_fwd = 0; m_odd = 0;
          m_ready = 0; m_err = 0; m_togo = (1 << W) - 1;
        end else if (seek_req) begin
          if (!m_ready || m_fault) m_err = 1;
          else if (want == m_cur) begin
            m_tgt = want; m_odd = want % 2; m_done = 1; m_err = 0;
          end else begin
            m_mode = 1; m_tgt = want; m_fwd = want > m_cur; m_odd = want % 2;
            m_seen = 0; m_err = 0;
            m_togo = (want > m_cur) ? want - m_cur : m_cur - want;
          end
        end
      end else if (m_mode == 1) begin
        if (seek_req || rtz_req) m_err = 1;
        if (m_togo == 0 && on_cyl_in) begin
          m_mode = 0; m_cur = m_tgt; m_done = 1;
        end else if (cyl_pulse) begin
          m_seen = 1;
          if (m_togo > 0) m_togo = m_togo - 1;
        end
      end else begin
        if (seek_req) m_err = 1;
        if (on_cyl_in) begin
          m_mode = 0; m_ready = 1; m_done = 1; m_togo = 0;
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      bit sk;
      sk = (m_mode == 1);
      chk("R1 tracks_to_go", int'(tracks_to_go), m_togo);
      chk("R2 dir_fwd", int'(dir_fwd), int'(m_fwd));
      chk("R3 odd_cyl", int'(odd_cyl), int'(m_odd));
      chk("R3 servo_inv", int'(servo_inv), int'(!m_odd));
      chk("R4 ph_stop", int'(ph_stop), int'(sk && m_togo <= 1));
      chk("R4 ph_linear", int'(ph_linear), int'(sk && m_togo > 1 && m_togo <= LIN));
      chk("R4 ph_accel", int'(ph_accel), int'(sk && m_togo > LIN && !m_seen));
      chk("R4 ph_coarse", int'(ph_coarse), int'(sk && m_togo > LIN && m_seen));
      chk("R5 busy", int'(busy), int'(m_mode != 0));
      chk("R5 seek_done", int'(seek_done), int'(m_done));
      chk("R5 cur_cyl", int'(cur_cyl), m_cur);
      chk("R6 on_cyl", int'(on_cyl), int'(m_ready && m_mode == 0));
      chk("R7 seek_err", int'(seek_err), int'(m_err));
      chk("R8 ready", int'(ready), int'(m_ready));
      chk("R8 rtz_active", int'(rtz_active), int'(m_mode == 2));
      chk("R9 fault", int'(fault), int'(m_fault));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_seek(input int c);
    seek_cyl = W'(c); seek_req = 1'b1; cyc(1); seek_req = 1'b0;
  endtask

  task automatic do_rtz();
    rtz_req = 1'b1; cyc(1); rtz_req = 1'b0;
  endtask

  task automatic crossings(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      cyl_pulse = 1'b1; cyc(1); cyl_pulse = 1'b0; cyc(gap);
    end
  endtask

  task automatic land();
    on_cyl_in = 1'b1; cyc(1); on_cyl_in = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int cnt;
    cnt = 0;
    while (cnt < 100000) begin
      @(posedge clk);
      cnt++;
    end
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(3);
    cmp_en = 1'b1;
    // R10 reset state
    chk("R10 busy", int'(busy), 0);
    chk("R10 ready", int'(ready), 0);
    chk("R10 tracks_to_go", int'(tracks_to_go), 0);
    chk("R10 servo_inv", int'(servo_inv), 1);
    rst_n = 1'b1;
    cyc(2);

    // R7: seek before ready rejected
    do_seek(5);
    chk("R7 not-ready reject", int'(seek_err), 1);
    chk("R7 not-ready busy", int'(busy), 0);

    // R8: return to zero, crossings ignored
    do_rtz();
    chk("R8 rtz busy", int'(rtz_active), 1);
    chk("R8 rtz count", int'(tracks_to_go), 511);
    crossings(3, 1);
    chk("R8 pulses ignored", int'(tracks_to_go), 511);
    cyc(2);
    land();
    chk("R8 arrival done", int'(seek_done), 1);
    chk("R8 ready", int'(ready), 1);
    chk("R8 count zero", int'(tracks_to_go), 0);

    // R1..R5: forward seek 0 -> 150
    do_seek(150);
    chk("R1 preload", int'(tracks_to_go), 150);
    chk("R2 forward", int'(dir_fwd), 1);
    chk("R3 even target inverts", int'(servo_inv), 1);
    chk("R4 accel", int'(ph_accel), 1);
    crossings(1, 0);
    chk("R4 coarse", int'(ph_coarse), 1);
    crossings(117, 1);
    chk("R4 linear at 32", int'(ph_linear), 1);
    crossings(31, 0);
    chk("R4 stop at one", int'(ph_stop), 1);
    crossings(1, 0);
    crossings(2, 0);
    chk("R1 hold at zero", int'(tracks_to_go), 0);
    cyc(2);
    land();
    chk("R5 done", int'(seek_done), 1);
    chk("R5 cur", int'(cur_cyl), 150);
    chk("R5 idle", int'(busy), 0);
    cyc(1);

    // R2, R3: reverse seek to even 10
    do_seek(10);
    chk("R2 reverse", int'(dir_fwd), 0);
    crossings(140, 0);
    land();
    cyc(1);

    // R6: zero length
    do_seek(10);
    chk("R6 done", int'(seek_done), 1);
    chk("R6 busy", int'(busy), 0);
    chk("R6 on_cyl", int'(on_cyl), 1);

    // R7: request mid-seek, then collision with completion
    do_seek(45);
    crossings(5, 0);
    do_seek(300);
    chk("R7 busy reject", int'(seek_err), 1);
    chk("R7 count kept", int'(tracks_to_go), 30);
    crossings(30, 0);
    seek_cyl = 9'd7; seek_req = 1'b1; on_cyl_in = 1'b1; cyc(1);
    seek_req = 1'b0; on_cyl_in = 1'b0;
    chk("R5 collision done", int'(seek_done), 1);
    chk("R7 collision reject", int'(seek_err), 1);
    chk("R5 collision cur", int'(cur_cyl), 45);
    do_seek(7);
    chk("R7 err cleared", int'(seek_err), 0);
    chk("R3 odd passes", int'(servo_inv), 0);
    crossings(38, 0);
    land();
    cyc(1);

    // R9: short dropout tolerated, full dropout faults
    do_seek(100);
    crossings(10, 0);
    dibit_ok = 1'b0; cyc(LOSS - 1); dibit_ok = 1'b1; cyc(1);
    chk("R9 short dropout", int'(fault), 0);
    dibit_ok = 1'b0; cyc(LOSS); dibit_ok = 1'b1;
    chk("R9 fault set", int'(fault), 1);
    chk("R9 aborted", int'(busy), 0);
    do_rtz();
    chk("R9 rtz refused", int'(busy), 0);
    do_seek(3);
    chk("R9 seek refused", int'(seek_err), 1);
    fault_clr = 1'b1; cyc(1); fault_clr = 1'b0;
    chk("R9 cleared", int'(fault), 0);
    do_rtz();
    do_seek(9);
    chk("R7 seek in rtz refused", int'(seek_err), 1);
    land();
    chk("R8 re-ready", int'(ready), 1);
    cyc(3);
    summary();
  end
endmodule